// File: doc/BRIEF.md
# Mailbox Command Protocol Sequencer

This block is the controller-side sequencer for a byte mailbox shared with a host processor. The mailbox raises an input-full flag when the host writes a byte. A companion flag tells whether that byte went to the command port or to the data port. The mailbox raises an output-full flag while a byte the controller loaded has not yet been read. The sequencer turns the mailbox's input-event and output-event pulses into the steps of a multi-byte command exchange. It clears the flags in a fixed order, loads response bytes, and accepts parameter bytes. It raises the output-event enable only while more steps still follow.

Events that arrive while a step is in progress are parked in one pending bit per event type and serviced when the step is over. When both are pending, the input event goes first. A new command always aborts the one in progress. Any stale response byte still waiting in the mailbox is cleared before the new command's input flag is released. A host that polls for "input empty and output full" therefore can never pick up leftover data.

The command set is a small example table in place of real command semantics. It contains a no-data command, a one-byte and a two-byte read of a scratch byte, a one-byte write of that scratch byte, and an echo. The echo takes one byte in and returns one byte out.

Top module: `cps_seq`

## Requirements
- R1: After reset and after any command completes, `obf_ie` is 0 and no clear or load pulse is issued while no event is pending.
- R2: An input event with `mb_is_cmd`=1 cancels any command in progress. The old command loads no further bytes, and later data bytes are not consumed on its behalf.
- R3: On a new command, `clr_obf` is pulsed (when `mb_obf`=1) in a cycle strictly before the `clr_ibf` pulse for that command. The two pulses are never asserted in the same cycle.
- R4: The sequencer takes the command byte from `mb_in_byte` and pulses `clr_ibf` before it decodes the command. `clr_ibf` is only pulsed while `mb_ibf`=1.
- R5: When a send step is the last step, the byte is loaded with `out_we`, `obf_ie` stays 0, and the sequencer returns to idle. Code 0x11 returns the scratch byte, whose reset value is 0x3C.
- R6: When a send step is not the last step, `obf_ie` is 1 once the byte is loaded. The next output event (host read) loads the following byte. Code 0x12 returns the scratch byte, then its bitwise inverse.
- R7: A receive step leaves `obf_ie` at 0 and waits. A data-port byte is read, `clr_ibf` is pulsed, the byte is consumed, and the command advances. Code 0x13 stores the byte as the new scratch byte. Code 0x14 takes one byte and returns its bitwise inverse.
- R8: Code 0x10 and every code not listed above transfer no data, load no byte, and finish with `obf_ie`=0.
- R9: An event that arrives while a step is being processed stays pending until the sequencer is back at rest. It is then serviced, never dropped.
- R10: When an input event and an output event are both pending at rest, the input event is serviced first.
- R11: A data-port byte that arrives when no receive step is expected is released with `clr_ibf` and otherwise ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ibf_evt | input | 1 | One-cycle pulse: host wrote a byte while input flag was empty |
| obf_evt | input | 1 | One-cycle pulse: host read the output byte |
| mb_ibf | input | 1 | Mailbox input-full flag |
| mb_obf | input | 1 | Mailbox output-full flag |
| mb_is_cmd | input | 1 | 1 when the pending input byte was written to the command port |
| mb_in_byte | input | DW | Pending input byte |
| clr_ibf | output | 1 | Pulse: clear the mailbox input-full flag |
| clr_obf | output | 1 | Pulse: clear the mailbox output-full flag |
| out_we | output | 1 | Pulse: load `out_byte` into the mailbox, setting output-full |
| out_byte | output | DW | Response byte |
| obf_ie | output | 1 | Output-event enable |

## Verification
The exchange is driven with back-to-back command and data writes, and with reads abandoned halfway so that a stale byte stays in the mailbox. A read that comes back equal to the new command's byte, rather than the stale one, separates correct clear ordering from a missing or late output clear. Writes followed by reads of the scratch byte show whether data bytes are consumed only by a command still expecting them, and not after a cancel. A host read issued in the same cycle as a new command write exercises both pending bits together. A random mix of all table codes, unknown codes and abandon points is checked against a host-side model of the scratch byte.

// File: rtl/cps_pkg.sv
package cps_pkg;
   localparam int MAX_STEPS = 2;

   typedef enum logic [1:0] {
      ST_REST   = 2'd0,
      ST_CLROBF = 2'd1,
      ST_TAKE   = 2'd2,
      ST_STEP   = 2'd3
   } cps_state_e;

   localparam logic [7:0] OP_NOP  = 8'h10;
   localparam logic [7:0] OP_RD1  = 8'h11;
   localparam logic [7:0] OP_RD2  = 8'h12;
   localparam logic [7:0] OP_WR1  = 8'h13;
   localparam logic [7:0] OP_ECHO = 8'h14;

   localparam int EV_IBF = 0;
   localparam int EV_OBF = 1;
   localparam int EV_N   = 2;
endpackage

// File: rtl/cps_evt_hold.sv
module cps_evt_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic en,
   input  logic ack,
   output logic pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= (pend & ~ack) | (evt & en);
   end
endmodule

// File: rtl/cps_cmd_table.sv
module cps_cmd_table #(
   parameter int DW          = 8,
   parameter int IW          = 2,
   parameter bit ECHO_INVERT = 1'b1
) (
   input  logic [DW-1:0] cmd,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] scratch,
   input  logic [DW-1:0] echo_val,
   output logic [IW-1:0] n_steps,
   output logic          is_send,
   output logic [DW-1:0] send_byte
);
   import cps_pkg::*;

   logic [DW-1:0] echo_ret;

   generate
      if (ECHO_INVERT) begin : g_echo_inv
         assign echo_ret = ~echo_val;
      end else begin : g_echo_plain
         assign echo_ret = echo_val;
      end
   endgenerate

   always_comb begin
      n_steps   = '0;
      is_send   = 1'b0;
      send_byte = '0;
      if (cmd == DW'(OP_RD1)) begin
         n_steps   = IW'(1);
         is_send   = 1'b1;
         send_byte = scratch;
      end else if (cmd == DW'(OP_RD2)) begin
         n_steps   = IW'(2);
         is_send   = 1'b1;
         send_byte = (idx == '0) ? scratch : ~scratch;
      end else if (cmd == DW'(OP_WR1)) begin
         n_steps   = IW'(1);
      end else if (cmd == DW'(OP_ECHO)) begin
         n_steps   = IW'(2);
         is_send   = (idx != '0);
         send_byte = echo_ret;
      end
   end
endmodule

// File: rtl/cps_seq.sv
module cps_seq #(
   parameter int          DW           = 8,
   parameter logic [7:0]  SCRATCH_INIT = 8'h3C,
   parameter bit          ECHO_INVERT  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ibf_evt,
   input  logic          obf_evt,
   input  logic          mb_ibf,
   input  logic          mb_obf,
   input  logic          mb_is_cmd,
   input  logic [DW-1:0] mb_in_byte,
   output logic          clr_ibf,
   output logic          clr_obf,
   output logic          out_we,
   output logic [DW-1:0] out_byte,
   output logic          obf_ie
);
   import cps_pkg::*;

   localparam int IW = $clog2(MAX_STEPS + 1);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("cps_seq: DW must be at least 8");
      end
   endgenerate

   cps_state_e      st;
   logic            active;
   logic            take_cmd;
   logic [DW-1:0]   cmd;
   logic [IW-1:0]   idx;
   logic [DW-1:0]   scratch;
   logic [DW-1:0]   echo_val;
   logic [IW-1:0]   n_steps;
   logic            is_send;
   logic [DW-1:0]   send_byte;
   logic            more_left;

   logic [EV_N-1:0] evt_v, en_v, ack_v, pend;

   assign evt_v[EV_IBF] = ibf_evt;
   assign evt_v[EV_OBF] = obf_evt;
   assign en_v[EV_IBF]  = 1'b1;
   assign en_v[EV_OBF]  = obf_ie;
   assign ack_v[EV_IBF] = (st == ST_REST) && pend[EV_IBF];
   assign ack_v[EV_OBF] = (st == ST_REST) && !pend[EV_IBF] && pend[EV_OBF];

   for (genvar g = 0; g < EV_N; g++) begin : g_hold
      cps_evt_hold u_hold (
         .clk  (clk),
         .rst_n(rst_n),
         .evt  (evt_v[g]),
         .en   (en_v[g]),
         .ack  (ack_v[g]),
         .pend (pend[g])
      );
   end

   cps_cmd_table #(.DW(DW), .IW(IW), .ECHO_INVERT(ECHO_INVERT)) u_table (
      .cmd      (cmd),
      .idx      (idx),
      .scratch  (scratch),
      .echo_val (echo_val),
      .n_steps  (n_steps),
      .is_send  (is_send),
      .send_byte(send_byte)
   );

   assign more_left = active && (idx < n_steps);
   assign clr_obf   = (st == ST_CLROBF) && mb_obf;
   assign clr_ibf   = (st == ST_TAKE);
   assign out_we    = (st == ST_STEP) && more_left && is_send;
   assign out_byte  = send_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_REST;
         active   <= 1'b0;
         take_cmd <= 1'b0;
         cmd      <= '0;
         idx      <= '0;
         scratch  <= DW'(SCRATCH_INIT);
         echo_val <= '0;
         obf_ie   <= 1'b0;
      end else begin
         unique case (st)
            ST_REST: begin
               if (ack_v[EV_IBF]) begin
                  take_cmd <= mb_is_cmd;
                  st       <= mb_is_cmd ? ST_CLROBF : ST_TAKE;
               end else if (ack_v[EV_OBF]) begin
                  st <= active ? ST_STEP : ST_REST;
               end
            end
            ST_CLROBF: begin
               active <= 1'b0;
               obf_ie <= 1'b0;
               st     <= ST_TAKE;
            end
            ST_TAKE: begin
               if (take_cmd) begin
                  cmd    <= mb_in_byte;
                  idx    <= '0;
                  active <= 1'b1;
                  st     <= ST_STEP;
               end else if (more_left && !is_send) begin
                  if (cmd == DW'(OP_WR1))  scratch  <= mb_in_byte;
                  if (cmd == DW'(OP_ECHO)) echo_val <= mb_in_byte;
                  idx <= idx + 1'b1;
                  st  <= ST_STEP;
               end else begin
                  st <= ST_REST;
               end
            end
            ST_STEP: begin
               st <= ST_REST;
               if (!more_left) begin
                  active <= 1'b0;
                  obf_ie <= 1'b0;
               end else if (is_send) begin
                  idx <= idx + 1'b1;
                  if (idx + 1'b1 >= n_steps) begin
                     active <= 1'b0;
                     obf_ie <= 1'b0;
                  end else begin
                     obf_ie <= 1'b1;
                  end
               end else begin
                  obf_ie <= 1'b0;
               end
            end
            default: st <= ST_REST;
         endcase
      end
   end
endmodule

// File: rtl/cps_seq_chk.sv
module cps_seq_chk (
   input logic              clk,
   input logic              rst_n,
   input cps_pkg::cps_state_e st,
   input logic              active,
   input logic              take_cmd,
   input logic [1:0]        pend,
   input logic              clr_ibf,
   input logic              clr_obf,
   input logic              out_we,
   input logic              obf_ie,
   input logic              mb_ibf,
   input logic              mb_obf
);
   import cps_pkg::*;

   AST_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_ibf && clr_obf)); // R3

   AST_STALE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TAKE && take_cmd) |-> !mb_obf); // R3

   AST_CLR_IBF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ibf |-> mb_ibf); // R4

   AST_IE_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(obf_ie) |-> $past(out_we)); // R6

   AST_IDLE_IE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_REST && !active) |-> !obf_ie); // R1

   AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[EV_IBF] && st != ST_REST) |=> pend[EV_IBF]); // R9

   AST_IBF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_REST && pend[EV_IBF] && pend[EV_OBF]) |=> (st != ST_STEP)); // R10
endmodule

bind cps_seq cps_seq_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .st      (st),
   .active  (active),
   .take_cmd(take_cmd),
   .pend    (pend),
   .clr_ibf (clr_ibf),
   .clr_obf (clr_obf),
   .out_we  (out_we),
   .obf_ie  (obf_ie),
   .mb_ibf  (mb_ibf),
   .mb_obf  (mb_obf)
);

// File: tb/sim_cps_seq.sv
`timescale 1ns/1ps
module sim_cps_seq;
   localparam logic [7:0] C_NOP = 8'h10, C_RD1 = 8'h11, C_RD2 = 8'h12,
                          C_WR1 = 8'h13, C_ECHO = 8'h14;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n;
   logic       ibf_evt, obf_evt, mb_ibf, mb_obf, mb_is_cmd;
   logic [7:0] mb_in_byte, mb_odata;
   logic       clr_ibf, clr_obf, out_we, obf_ie;
   logic [7:0] out_byte;

   int   n_run = 0, n_fail = 0;
   logic [7:0] scr_m;

   cps_seq u0 (
      .clk(clk), .rst_n(rst_n), .ibf_evt(ibf_evt), .obf_evt(obf_evt),
      .mb_ibf(mb_ibf), .mb_obf(mb_obf), .mb_is_cmd(mb_is_cmd),
      .mb_in_byte(mb_in_byte), .clr_ibf(clr_ibf), .clr_obf(clr_obf),
      .out_we(out_we), .out_byte(out_byte), .obf_ie(obf_ie)
   );

   function automatic logic [7:0] f_inv(input logic [7:0] b);
      return ~b;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // mailbox model: applies the pulses of the cycle that ends at this edge
   task automatic tick();
      bit co, ci, we;
      logic [7:0] ob;
      co = clr_obf; ci = clr_ibf; we = out_we; ob = out_byte;
      @(posedge clk);
      #1;
      ibf_evt = 1'b0;
      obf_evt = 1'b0;
      if (co) mb_obf = 1'b0;
      if (ci) mb_ibf = 1'b0;
      if (we) begin mb_obf = 1'b1; mb_odata = ob; end
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic hwrite(input bit is_cmd, input logic [7:0] b, input bit do_tick);
      int g = 0;
      while (mb_ibf && g < 100) begin tick(); g++; end
      mb_ibf = 1'b1; mb_is_cmd = is_cmd; mb_in_byte = b; ibf_evt = 1'b1;
      if (do_tick) tick();
   endtask

   task automatic wait_ready(output bit ok);
      int g = 0;
      while (!(!mb_ibf && mb_obf) && g < 60) begin tick(); g++; end
      ok = (!mb_ibf && mb_obf);
   endtask

   task automatic hread(input string req, input logic [7:0] exp);
      bit ok;
      wait_ready(ok);
      chk(ok, req, int'(ok), 1);
      if (ok) begin
         chk(mb_odata == exp, req, mb_odata, exp);
         mb_obf = 1'b0; obf_evt = 1'b1;
         tick();
      end
   endtask

   task automatic check_done(input string req);
      quiet(8);
      chk(!obf_ie && !mb_obf && !mb_ibf, req, {obf_ie, mb_obf, mb_ibf}, 0);
   endtask

   // abandon: 0 = complete, 1 = stop early
   task automatic run_cmd(input logic [7:0] code, input logic [7:0] d, input bit abandon);
      bit ok;
      hwrite(1'b1, code, 1'b1);
      case (code)
         C_RD1: if (!abandon) begin hread("R5 read1", scr_m); check_done("R5 done"); end
         C_RD2: begin
            wait_ready(ok);
            chk(obf_ie == 1'b1, "R6 obf_ie", obf_ie, 1);
            hread("R6 first", scr_m);
            if (!abandon) begin hread("R6 second", f_inv(scr_m)); check_done("R6 done"); end
         end
         C_WR1: if (!abandon) begin
            hwrite(1'b0, d, 1'b1); scr_m = d; check_done("R7 write");
         end
         C_ECHO: if (!abandon) begin
            hwrite(1'b0, d, 1'b1); hread("R7 echo", f_inv(d)); check_done("R7 echo done");
         end
         default: check_done("R8 no data");
      endcase
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] codes [6];
      void'($urandom(32'h5EED));
      codes = '{C_NOP, C_RD1, C_RD2, C_WR1, C_ECHO, 8'hEE};
      rst_n = 1'b0; ibf_evt = 0; obf_evt = 0; mb_ibf = 0; mb_obf = 0;
      mb_is_cmd = 0; mb_in_byte = 0; mb_odata = 0;
      scr_m = 8'h3C;
      quiet(3);
      rst_n = 1'b1;
      quiet(3);
      // R1 reset state
      chk(!obf_ie && !clr_ibf && !clr_obf && !out_we, "R1 reset",
          {obf_ie, clr_ibf, clr_obf, out_we}, 0);

      run_cmd(C_RD1, 0, 0);           // R5 reset scratch
      run_cmd(C_WR1, 8'h81, 0);       // R7
      run_cmd(C_RD1, 0, 0);
      run_cmd(C_ECHO, 8'h0F, 0);      // R7
      run_cmd(C_RD2, 0, 0);           // R6
      run_cmd(C_NOP, 0, 0);           // R8
      run_cmd(8'hEE, 0, 0);           // R8 unknown

      // R3 stale byte left unread must not reach the host
      hwrite(1'b1, C_RD2, 1'b1);
      quiet(10);
      hwrite(1'b1, C_RD1, 1'b1);
      hread("R3 stale cleared", scr_m);
      check_done("R3 done");

      // R2 cancel a pending write, then R11 stray data is dropped
      hwrite(1'b1, C_WR1, 1'b1);
      quiet(5);
      hwrite(1'b1, C_RD1, 1'b1);
      hread("R2 cancel read", scr_m);
      hwrite(1'b0, 8'h55, 1'b1);
      quiet(8);
      chk(!mb_ibf && !mb_obf, "R11 stray released", {mb_ibf, mb_obf}, 0);
      run_cmd(C_RD1, 0, 0);           // R2: scratch unchanged

      // R9 data written right behind the command, while a step runs
      hwrite(1'b1, C_ECHO, 1'b0);
      hwrite(1'b0, 8'hA6, 1'b1);
      hread("R9 held data", 8'h59);
      check_done("R9 done");

      // R10 host read and new command in the same cycle
      hwrite(1'b1, C_RD2, 1'b1);
      begin
         bit ok;
         wait_ready(ok);
         chk(ok, "R10 ready", int'(ok), 1);
         mb_obf = 1'b0; obf_evt = 1'b1;
         mb_ibf = 1'b1; mb_is_cmd = 1'b1; mb_in_byte = C_RD1; ibf_evt = 1'b1;
         tick();
      end
      hread("R10 new cmd first", scr_m);
      check_done("R10 done");

      // random mix
      for (int i = 0; i < 150; i++) begin
         logic [7:0] c, d;
         bit ab;
         c  = codes[$urandom_range(0, 5)];
         d  = 8'($urandom);
         ab = ($urandom_range(0, 3) == 0);
         run_cmd(c, d, ab);
      end
      run_cmd(C_RD1, 0, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule